// File: doc/BRIEF.md
# Overdrive Table Loader with Serial-Memory Fallback

After reset this block fills a small on-chip lookup table that an overdrive engine later consults for its gray-level correction values. It first tries an external serial memory on a two-wire bus. It addresses the device for writing and sets a two-byte word pointer of zero. It then issues a repeated start, re-addresses the device for reading and streams the whole table out in one sequential burst. When the device does not acknowledge its address, the block closes the bus and loads the table from an internal constant pattern instead. It makes no retry.

The overdrive engine reads the table through a combinational read port. The port returns zero until every entry has been written. A ready flag and a source flag tell the rest of the chip when the table can be used and where its contents came from.

Top module: `od_table_loader`

## Requirements
- R1: While reset is low and just after it is released, `loaded` and `src_rom` are 0, `rd_data` is 0, and both bus lines are released (`scl_o` = 1, `sda_o` = 1).
- R2: Before any data is read, the block sends these bytes in this order: a start; the device address with the direction bit 0 (0xA0 for the default address 0x50); two word-address bytes of 0x00; a repeated start; and the device address with the direction bit 1 (0xA1).
- R3: The burst reads exactly ENTRIES bytes. The block acknowledges (SDA low) every byte except the last. It leaves the last byte unacknowledged and then sends a stop (SDA rising while SCL is high).
- R4: When the serial memory is the source, table entry i holds the i-th byte of the burst, counted from 0.
- R5: When the device-address byte gets no acknowledge, the block sends a stop and never sends another start. It then fills entry i with (29*i + 17) mod 2^DW, one entry per clock.
- R6: `loaded` rises CLK_DIV clocks after SDA rises in the stop condition on the serial path, and CLK_DIV+ENTRIES clocks after it on the fallback path. It rises only after the last entry is written and stays high until reset.
- R7: While `loaded` is high, `src_rom` is 1 for the fallback source and 0 for the serial source, and it does not change.
- R8: While `loaded` is low, `rd_data` is 0 for every `rd_addr`. While `loaded` is high, `rd_data` is the table entry at `rd_addr`.
- R9: `scl_o` changes only on divider ticks, one tick every CLK_DIV clocks. Each completed SCL high pulse lasts 2*CLK_DIV clocks. While SCL is high inside a data or acknowledge bit, SDA driven by the block does not change.
- R10: A reset asserted in the middle of a load abandons it. The next load runs from the start and produces a correct table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts a load |
| scl_o | output | 1 | Serial clock; 1 releases the line, 0 pulls it low |
| sda_o | output | 1 | Serial data drive; 1 releases the line, 0 pulls it low |
| sda_i | input | 1 | Sensed level of the serial data line |
| rd_addr | input | $clog2(ENTRIES) | Table index from the overdrive engine |
| rd_data | output | DW | Table entry, or 0 before the load completes |
| loaded | output | 1 | Every table entry has been written |
| src_rom | output | 1 | The table came from the internal pattern |

## Verification
The bench goes after the absent-device decision. A design that ignored the address acknowledge would fill the table with all-ones bytes. A design that retried would send a second start. It also checks the final byte's acknowledge. If the block acknowledged the last byte, the memory model would keep driving data and the stop would collide with it. A design that stopped one byte short would leave the top table entry stale. Every clock, the read port is compared with a model that expects zero until its own predicted ready cycle. An early ready flag, or table contents exposed early, therefore shows up at once. A reset in the middle of a burst followed by a load with different memory contents catches a design that keeps partial state across reset.

// File: rtl/od_table_loader.sv
module od_table_loader #(
  parameter int ENTRIES = 32,
  parameter int DW = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int CLK_DIV = 4,
  localparam int AW = $clog2(ENTRIES),
  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          scl_o,
  output logic          sda_o,
  input  logic          sda_i,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          loaded,
  output logic          src_rom
);

  typedef enum logic [2:0] {S_START, S_TX, S_RX, S_STOP, S_ROM, S_DONE} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [1:0]    bidx;
  logic [AW-1:0] widx;
  logic [7:0]    sh;
  logic          nack_q, full_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0] tbl [ENTRIES];

  wire tick   = (div_q == DIVW'(CLK_DIV - 1));
  wire last_w = (widx == AW'(ENTRIES - 1));

  logic [7:0] tx_byte;
  always_comb begin
    case (bidx)
      2'd0:    tx_byte = {DEV_ADDR, 1'b0};
      2'd3:    tx_byte = {DEV_ADDR, 1'b1};
      default: tx_byte = 8'h00;
    endcase
  end

  wire tx_bit = bitn[3] ? 1'b1 : tx_byte[~bitn[2:0]];
  wire rx_drv = bitn[3] ? last_w : 1'b1;

  function automatic logic [DW-1:0] rom_val(input logic [AW-1:0] i);
    return DW'(32'(i) * 29 + 17);
  endfunction

  wire wr_rx  = (st == S_RX) && tick && (ph == 2'd3) && bitn[3];
  wire wr_en  = wr_rx || (st == S_ROM);
  wire [DW-1:0] wr_data = (st == S_ROM) ? rom_val(widx) : DW'(sh);

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tbl[widx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_START; ph <= '0; bitn <= '0; bidx <= '0; widx <= '0;
      sh <= '0; nack_q <= 1'b0; full_q <= 1'b0;
      scl_o <= 1'b1; sda_o <= 1'b1; loaded <= 1'b0; src_rom <= 1'b0;
    end else begin
      if (wr_en && last_w) full_q <= 1'b1;
      if (tick && (st == S_START || st == S_TX || st == S_RX || st == S_STOP))
        ph <= ph + 1'b1;
      case (st)
        S_START: if (tick) begin
          case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= 1'b1; end
            2'd1: scl_o <= 1'b1;
            2'd2: sda_o <= 1'b0;
            default: begin scl_o <= 1'b0; st <= S_TX; bitn <= '0; end
          endcase
        end
        S_TX: if (tick) begin
          case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= tx_bit; end
            2'd1: scl_o <= 1'b1;
            2'd2: if (bitn[3] && bidx == 2'd0) nack_q <= sda_i;
            default: begin
              scl_o <= 1'b0;
              if (bitn[3]) begin
                bitn <= '0;
                if (nack_q) begin
                  st <= S_STOP; src_rom <= 1'b1;
                end else if (bidx == 2'd2) begin
                  bidx <= 2'd3; st <= S_START;
                end else if (bidx == 2'd3) begin
                  st <= S_RX;
                end else begin
                  bidx <= bidx + 1'b1;
                end
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          endcase
        end
        S_RX: if (tick) begin
          case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= rx_drv; end
            2'd1: scl_o <= 1'b1;
            2'd2: if (!bitn[3]) sh <= {sh[6:0], sda_i};
            default: begin
              scl_o <= 1'b0;
              if (bitn[3]) begin
                bitn <= '0;
                if (last_w) st <= S_STOP;
                else        widx <= widx + 1'b1;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          endcase
        end
        S_STOP: if (tick) begin
          case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= 1'b0; end
            2'd1: scl_o <= 1'b1;
            2'd2: sda_o <= 1'b1;
            default: begin
              if (src_rom) begin
                st <= S_ROM; widx <= '0;
              end else begin
                st <= S_DONE; loaded <= 1'b1;
              end
            end
          endcase
        end
        S_ROM: begin
          if (last_w) begin st <= S_DONE; loaded <= 1'b1; end
          else        widx <= widx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rd_data = loaded ? tbl[rd_addr] : '0;

  p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> full_q);
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> $stable(src_rom));
  p_rom_after_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROM) |-> src_rom);
  p_scl_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o != $past(scl_o)) |-> $past(tick));
  p_sda_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX || st == S_RX) && st == $past(st) && scl_o && $past(scl_o))
      |-> $stable(sda_o));

endmodule

// File: tb/od_table_loader_test.sv
module od_table_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int E = 32;
  localparam int DIV = 4;
  localparam int AW = $clog2(E);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_o, sda_o, sda_i, loaded, src_rom;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic s_sda = 1'b1;

  assign sda_i = sda_o & s_sda;

  od_table_loader #(.ENTRIES(E), .DW(8), .DEV_ADDR(7'h50), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i),
    .rd_addr(rd_addr), .rd_data(rd_data), .loaded(loaded), .src_rom(src_rom));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit present = 1'b1;
  int seed = 1;

  // memory-model state
  bit pscl, psda, active, skipfall, rxm, pend, addressed, mack, exp_done, hi_meas;
  int bitn, ptr, nrx, sent, starts, cnt, hi_cnt;
  logic [7:0] shr, txb;
  int rxlog [4];

  function automatic int memv(int i); return (i * 13 + seed * 71 + 5) & 255; endfunction
  function automatic int romv(int i); return (i * 29 + 17) & 255; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      s_sda = 1'b1; pscl = 1'b1; psda = 1'b1; active = 0; skipfall = 0; rxm = 1;
      pend = 0; addressed = 0; mack = 1; exp_done = 0; hi_meas = 0;
      bitn = 0; ptr = 0; nrx = 0; sent = 0; starts = 0; cnt = 0; hi_cnt = 0;
      rd_addr <= rd_addr + 1'b1;
    end else begin
      logic sl, dl;
      int er;
      sl = scl_o; dl = sda_o & s_sda;
      if (cnt > 0) begin cnt--; if (cnt == 0) exp_done = 1; end
      er = !exp_done ? 0 : (present ? memv(int'(rd_addr)) : romv(int'(rd_addr)));
      chk(int'(rd_data) == er, !exp_done ? "R8" : (present ? "R4" : "R5"), int'(rd_data), er);
      chk(loaded == exp_done, "R6", int'(loaded), int'(exp_done));
      if (exp_done) chk(src_rom == !present, "R7", int'(src_rom), int'(!present));
      // SCL high-width measurement
      if (!pscl && sl) begin hi_meas = 1; hi_cnt = 0; end
      if (sl) hi_cnt++;
      if (pscl && !sl && hi_meas) chk(hi_cnt == 2*DIV, "R9", hi_cnt, 2*DIV);
      // bus conditions
      if (pscl && sl && psda && !dl) begin
        active = 1; skipfall = 1; bitn = 0; rxm = 1; starts++;
      end else if (pscl && sl && !psda && dl) begin
        active = 0; s_sda = 1'b1;
        cnt = present ? DIV : DIV + E;
      end else if (active && !pscl && sl) begin
        if (bitn < 8 && rxm) shr = {shr[6:0], dl};
        if (bitn == 8 && !rxm) begin
          mack = dl;
          chk(mack == (sent == E-1), "R3", int'(mack), int'(sent == E-1));
        end
      end else if (active && pscl && !sl) begin
        if (skipfall) skipfall = 0;
        else if (bitn < 8) begin
          bitn++;
          if (bitn == 8) begin
            if (rxm) begin
              if (nrx < 4) rxlog[nrx] = int'(shr);
              if (shr[7:1] == 7'h50) begin
                addressed = present;
                if (shr[0]) pend = present; else ptr = 0;
              end
              nrx++;
              s_sda = addressed ? 1'b0 : 1'b1;
            end else s_sda = 1'b1;
          end else if (!rxm) s_sda = txb[7-bitn];
        end else begin
          bitn = 0; s_sda = 1'b1;
          if (rxm && pend) begin
            rxm = 0; pend = 0; txb = 8'(memv(ptr)); s_sda = txb[7];
          end else if (!rxm) begin
            sent++; ptr++;
            if (!mack) begin txb = 8'(memv(ptr)); s_sda = txb[7]; end
          end
        end
      end
      pscl = sl; psda = dl;
      rd_addr <= rd_addr + 1'b1;
    end
  end

  task automatic wait_loaded();
    int t = 0;
    while (!loaded && t < 30000) begin @(posedge clk); t++; end
    repeat (E + 5) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(scl_o == 1 && sda_o == 1, "R1", int'({scl_o, sda_o}), 3);
    chk(loaded == 0 && src_rom == 0, "R1", int'({loaded, src_rom}), 0);
    chk(rd_data == 0, "R1", int'(rd_data), 0);
    rst_n = 1'b1;
  endtask

  task automatic end_checks_serial();
    chk(nrx == 4, "R2", nrx, 4);
    chk(rxlog[0] == 'hA0, "R2", rxlog[0], 'hA0);
    chk(rxlog[1] == 0, "R2", rxlog[1], 0);
    chk(rxlog[2] == 0, "R2", rxlog[2], 0);
    chk(rxlog[3] == 'hA1, "R2", rxlog[3], 'hA1);
    chk(starts == 2, "R2", starts, 2);
    chk(sent == E, "R3", sent, E);
    chk(loaded == 1 && src_rom == 0, "R7", int'({loaded, src_rom}), 2);
  endtask

  initial begin
    fork
      begin
        // serial source
        present = 1; seed = 1;
        do_reset();
        wait_loaded();
        end_checks_serial();
        // absent device, fallback
        present = 0;
        do_reset();
        wait_loaded();
        chk(starts == 1, "R5", starts, 1);
        chk(nrx == 1, "R5", nrx, 1);
        chk(loaded == 1 && src_rom == 1, "R7", int'({loaded, src_rom}), 3);
        // reset in mid-burst, then reload with new contents
        present = 1; seed = 2;
        do_reset();
        repeat (2500) @(posedge clk);
        chk(loaded == 0, "R10", int'(loaded), 0);
        seed = 3;
        do_reset();
        wait_loaded();
        end_checks_serial();
        chk(loaded == 1, "R10", int'(loaded), 1);
      end
      begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule